// File: doc/BRIEF.md
# Board Control and Timekeeping Register Bank

This block is a bank of 32-bit registers inside a 4 KB address window, reached through a plain strobe-based read/write port. Software uses it to drive a row of active-high user LEDs, read debounced-elsewhere push-button and switch levels, keep a scratch control word, and read two low-rate timekeeping counters. One counter advances once per second and the other once per hundredth of a second. Software can load either counter to set the current time, and counting carries on from the loaded value.

The bank also fronts a prescaled event counter. A down-counting prescaler steps on every prescale tick. When it is at zero, the next tick reloads it from a software reload register and adds one to an up-counting event count. The live prescaler, its reload value and the event count are all readable and writable. Register presence (debug word, switches), LED width, input widths and the system clock frequency are build parameters. A register that is not built behaves exactly like an empty address.

Top module: `brd_ctrl_regs`

## Requirements
- R1: An access is one cycle with `psel` high. A write updates its register at the clock edge of that cycle. A read places the register value as it stood before that edge on `prdata` after the edge. `prdata` holds its value in every cycle without a read strobe.
- R2: A write to word offset 0x00 keeps only the low NUM_LEDS bits of the data. Reading 0x00 returns those bits zero-extended. `led_o` bit i equals stored bit i, active high, one cycle after the write.
- R3: The debug word at 0x04 exists only when HAS_DBG=1, where it reads back as written. The switch word at 0x28 exists only when HAS_SW=1. A register that is not built reads as zero and ignores writes.
- R4: Any offset other than 0x00, 0x04, 0x08, 0x10, 0x14, 0x18, 0x1C, 0x20, 0x28 and 0x4C reads as zero. A write to such an offset changes no register. Address bits [1:0] are ignored.
- R5: The control word at 0x4C reads back all 32 bits exactly as last written and has no other effect.
- R6: Button levels read at 0x08 and switch levels read at 0x28 pass through a two-flop synchronizer. They are zero-extended to 32 bits.
- R7: The centisecond counter (0x14) increments every CLK_HZ/100 clocks and the second counter (0x10) every CLK_HZ clocks. A write loads the counter and restarts its divider, so the first increment after a write comes CLK_HZ/100 (or CLK_HZ) clocks after the write edge.
- R8: Both low-rate counters wrap from 0xFFFFFFFF to 0.
- R9: Synchronous reset clears the LED word, control word, debug word, both low-rate counters, the reload value (0x1C), the prescaler (0x20), the event count (0x18), `prdata` and `led_o`.
- R10: On each prescale tick (every PS_DIV clocks), a nonzero prescaler decrements by one. A zero prescaler reloads from 0x1C and the event count at 0x18 increments.
- R11: With a reload value of zero, the prescaler stays at zero and the event count increments on every prescale tick.
- R12: A write to 0x18, 0x1C or 0x20 loads that register on the write edge. The written value takes precedence over any tick update of the same register at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Access strobe, one cycle per access |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| btn_i | input | BTN_W | Asynchronous button levels |
| sw_i | input | SW_W | Asynchronous switch levels |
| led_o | output | NUM_LEDS | Active-high LED drives |

## Verification
The prescaled counter is tried from reset with a zero reload value, where the event count must move every tick. It is then tried with a reload of three and a short preloaded prescaler, which separates decrement, reload and event-increment timing. It is also tried with writes landing on tick edges, which shows whether a write wins over the tick. The low-rate counters are loaded and read one cycle either side of their first divider tick, and the second counter is also loaded with all ones to expose the wrap. Address patterns cover built, unbuilt and empty offsets, all-ones data to the LED word for masking, and a mid-run reset after every register has been dirtied.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = ADDR_W - 2;

  typedef logic [IDX_W-1:0] idx_t;

  // word indices (byte offset / 4)
  localparam idx_t IX_LED  = 10'd0;
  localparam idx_t IX_DBG  = 10'd1;
  localparam idx_t IX_BTN  = 10'd2;
  localparam idx_t IX_SEC  = 10'd4;
  localparam idx_t IX_CSEC = 10'd5;
  localparam idx_t IX_CNT  = 10'd6;
  localparam idx_t IX_PRE  = 10'd7;
  localparam idx_t IX_PSC  = 10'd8;
  localparam idx_t IX_SW   = 10'd10;
  localparam idx_t IX_MISC = 10'd19;
endpackage

// File: rtl/brd_tick_div.sv
module brd_tick_div #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst ^ clr;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      assign tick = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/brd_rate_counter.sv
module brd_rate_counter #(
  parameter int unsigned DIV = 100,
  parameter int          W   = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count
);
  logic tick;

  brd_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (wr),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (wr)   count <= wdata;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/brd_prescale_cnt.sv
module brd_prescale_cnt #(
  parameter int unsigned PS_DIV = 1,
  parameter int          W      = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cnt,
  input  logic         wr_psc,
  input  logic         wr_pre,
  input  logic [W-1:0] wdata,
  output logic         tick_o,
  output logic [W-1:0] counter_o,
  output logic [W-1:0] pscntr_o,
  output logic [W-1:0] prescale_o
);
  logic         at_zero;
  logic [W-1:0] psc_nxt;
  logic [W-1:0] cnt_nxt;

  brd_tick_div #(.DIV(PS_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (1'b0),
    .tick (tick_o)
  );

  assign at_zero = (pscntr_o == '0);

  always_comb begin
    psc_nxt = pscntr_o;
    cnt_nxt = counter_o;
    if (tick_o) begin
      if (at_zero) begin
        psc_nxt = prescale_o;
        cnt_nxt = counter_o + 1'b1;
      end else begin
        psc_nxt = pscntr_o - 1'b1;
      end
    end
    if (wr_psc) psc_nxt = wdata;
    if (wr_cnt) cnt_nxt = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pscntr_o   <= '0;
      counter_o  <= '0;
      prescale_o <= '0;
    end else begin
      pscntr_o  <= psc_nxt;
      counter_o <= cnt_nxt;
      if (wr_pre) prescale_o <= wdata;
    end
  end
endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import brd_ctrl_pkg::*;
#(
  parameter int          NUM_LEDS = 2,
  parameter int          BTN_W    = 2,
  parameter int          SW_W     = 8,
  parameter bit          HAS_DBG  = 1'b0,
  parameter bit          HAS_SW   = 1'b0,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PS_DIV   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [BTN_W-1:0]  btn_i,
  input  logic [SW_W-1:0]   sw_i,
  output logic [NUM_LEDS-1:0] led_o
);
  localparam int unsigned CSEC_DIV = CLK_HZ / 100;
  localparam int unsigned SEC_DIV  = CLK_HZ;

  idx_t idx;
  logic unused_lsb;
  logic wr_en, rd_en;
  logic wr_led, wr_dbg, wr_misc, wr_sec, wr_csec, wr_cnt, wr_pre, wr_psc;

  assign idx        = paddr[ADDR_W-1:2];
  assign unused_lsb = ^paddr[1:0];
  assign wr_en      = psel & pwrite;
  assign rd_en      = psel & ~pwrite;

  assign wr_led  = wr_en && (idx == IX_LED);
  assign wr_dbg  = wr_en && (idx == IX_DBG);
  assign wr_misc = wr_en && (idx == IX_MISC);
  assign wr_sec  = wr_en && (idx == IX_SEC);
  assign wr_csec = wr_en && (idx == IX_CSEC);
  assign wr_cnt  = wr_en && (idx == IX_CNT);
  assign wr_pre  = wr_en && (idx == IX_PRE);
  assign wr_psc  = wr_en && (idx == IX_PSC);

  // ---------------- plain storage ----------------
  logic [NUM_LEDS-1:0] led_q;
  logic [DATA_W-1:0]   misc_q;
  logic [DATA_W-1:0]   dbg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q  <= '0;
      misc_q <= '0;
    end else begin
      if (wr_led)  led_q  <= pwdata[NUM_LEDS-1:0];
      if (wr_misc) misc_q <= pwdata;
    end
  end

  assign led_o = led_q;

  generate
    if (HAS_DBG) begin : g_dbg
      always_ff @(posedge clk) begin
        if (rst)         dbg_q <= '0;
        else if (wr_dbg) dbg_q <= pwdata;
      end
    end else begin : g_no_dbg
      logic unused_dbg;
      assign unused_dbg = wr_dbg;
      assign dbg_q      = '0;
    end
  endgenerate

  // ---------------- input synchronizers ----------------
  logic [BTN_W-1:0] btn_s;
  logic [SW_W-1:0]  sw_s;

  brd_sync #(.W(BTN_W)) u_btn_sync (
    .clk (clk),
    .rst (rst),
    .d_i (btn_i),
    .q_o (btn_s)
  );

  generate
    if (HAS_SW) begin : g_sw
      brd_sync #(.W(SW_W)) u_sw_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sw_i),
        .q_o (sw_s)
      );
    end else begin : g_no_sw
      logic unused_sw;
      assign unused_sw = ^sw_i;
      assign sw_s      = '0;
    end
  endgenerate

  // ---------------- low-rate counters ----------------
  logic [DATA_W-1:0] sec_cnt, csec_cnt;

  brd_rate_counter #(.DIV(SEC_DIV), .W(DATA_W)) u_sec (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_sec),
    .wdata (pwdata),
    .count (sec_cnt)
  );

  brd_rate_counter #(.DIV(CSEC_DIV), .W(DATA_W)) u_csec (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_csec),
    .wdata (pwdata),
    .count (csec_cnt)
  );

  // ---------------- prescaled event counter ----------------
  logic              ps_tick;
  logic [DATA_W-1:0] counter_q, pscntr_q, prescale_q;

  brd_prescale_cnt #(.PS_DIV(PS_DIV), .W(DATA_W)) u_ps (
    .clk        (clk),
    .rst        (rst),
    .wr_cnt     (wr_cnt),
    .wr_psc     (wr_psc),
    .wr_pre     (wr_pre),
    .wdata      (pwdata),
    .tick_o     (ps_tick),
    .counter_o  (counter_q),
    .pscntr_o   (pscntr_q),
    .prescale_o (prescale_q)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    case (idx)
      IX_LED:  rd_val = DATA_W'(led_q);
      IX_DBG:  rd_val = dbg_q;
      IX_BTN:  rd_val = DATA_W'(btn_s);
      IX_SEC:  rd_val = sec_cnt;
      IX_CSEC: rd_val = csec_cnt;
      IX_CNT:  rd_val = counter_q;
      IX_PRE:  rd_val = prescale_q;
      IX_PSC:  rd_val = pscntr_q;
      IX_SW:   rd_val = DATA_W'(sw_s);
      IX_MISC: rd_val = misc_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        prdata <= '0;
    else if (rd_en) prdata <= rd_val;
  end
endmodule

// File: rtl/brd_ctrl_regs_chk.sv
module brd_ctrl_regs_chk
  import brd_ctrl_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter bit HAS_DBG  = 1'b0,
  parameter bit HAS_SW   = 1'b0
) (
  input logic                clk,
  input logic                rst,
  input logic                psel,
  input logic                pwrite,
  input logic [ADDR_W-1:0]   paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic [DATA_W-1:0]   prdata,
  input logic [NUM_LEDS-1:0] led_o,
  input logic                ps_tick,
  input logic [DATA_W-1:0]   pscntr_q,
  input logic [DATA_W-1:0]   prescale_q,
  input logic [DATA_W-1:0]   counter_q
);
  idx_t a_idx;
  logic a_wr, a_rd, a_mapped, a_wr_psc, a_wr_cnt;

  assign a_idx    = paddr[ADDR_W-1:2];
  assign a_wr     = psel && pwrite;
  assign a_rd     = psel && !pwrite;
  assign a_wr_psc = a_wr && (a_idx == IX_PSC);
  assign a_wr_cnt = a_wr && (a_idx == IX_CNT);
  assign a_mapped = (a_idx == IX_LED) || (a_idx == IX_BTN) || (a_idx == IX_SEC) ||
                    (a_idx == IX_CSEC) || (a_idx == IX_CNT) || (a_idx == IX_PRE) ||
                    (a_idx == IX_PSC) || (a_idx == IX_MISC) ||
                    (HAS_DBG && (a_idx == IX_DBG)) || (HAS_SW && (a_idx == IX_SW));

  assert_prdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !a_rd |=> $stable(prdata));

  assert_led_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
    (a_wr && a_idx == IX_LED) |=> (led_o == $past(pwdata[NUM_LEDS-1:0])));

  assert_unmapped_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (a_rd && !a_mapped) |=> (prdata == '0));

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (prdata == '0 && led_o == '0 && counter_q == '0 &&
                    pscntr_q == '0 && prescale_q == '0));

  assert_ps_decrement_R10: assert property (@(posedge clk) disable iff (rst)
    (ps_tick && pscntr_q != '0 && !a_wr_psc) |=> (pscntr_q == $past(pscntr_q) - 1'b1));

  assert_ps_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (ps_tick && pscntr_q == '0 && !a_wr_psc) |=> (pscntr_q == $past(prescale_q)));

  assert_event_count_R10: assert property (@(posedge clk) disable iff (rst)
    (ps_tick && pscntr_q == '0 && !a_wr_cnt) |=> (counter_q == $past(counter_q) + 1'b1));

  assert_zero_reload_sticks_R11: assert property (@(posedge clk) disable iff (rst)
    (ps_tick && pscntr_q == '0 && prescale_q == '0 && !a_wr_psc) |=> (pscntr_q == '0));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
    a_wr_psc |=> (pscntr_q == $past(pwdata)));
endmodule

bind brd_ctrl_regs brd_ctrl_regs_chk #(
  .NUM_LEDS (NUM_LEDS),
  .HAS_DBG  (HAS_DBG),
  .HAS_SW   (HAS_SW)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .psel       (psel),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .prdata     (prdata),
  .led_o      (led_o),
  .ps_tick    (ps_tick),
  .pscntr_q   (pscntr_q),
  .prescale_q (prescale_q),
  .counter_q  (counter_q)
);

// File: tb/brd_ctrl_regs_tb_top.sv
module brd_ctrl_regs_tb_top;
  localparam int NL    = 2;
  localparam int BW    = 4;
  localparam int SWW   = 4;
  localparam int HZ    = 2000;   // 100 Hz divider = 20, 1 Hz divider = 2000

  localparam logic [11:0] A_LED  = 12'h000;
  localparam logic [11:0] A_DBG  = 12'h004;
  localparam logic [11:0] A_BTN  = 12'h008;
  localparam logic [11:0] A_HOLE = 12'h00C;
  localparam logic [11:0] A_SEC  = 12'h010;
  localparam logic [11:0] A_CSEC = 12'h014;
  localparam logic [11:0] A_CNT  = 12'h018;
  localparam logic [11:0] A_PRE  = 12'h01C;
  localparam logic [11:0] A_PSC  = 12'h020;
  localparam logic [11:0] A_SW   = 12'h028;
  localparam logic [11:0] A_EMPT = 12'h030;
  localparam logic [11:0] A_MISC = 12'h04C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [BW-1:0]  btn_i = '0;
  logic [SWW-1:0] sw_i = '0;
  logic [NL-1:0]  led_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rd_seen = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  brd_ctrl_regs #(
    .NUM_LEDS (NL),
    .BTN_W    (BW),
    .SW_W     (SWW),
    .HAS_DBG  (1'b0),
    .HAS_SW   (1'b1),
    .CLK_HZ   (HZ),
    .PS_DIV   (1)
  ) dut_i (
    .clk    (clk),
    .rst    (rst),
    .psel   (psel),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .prdata (prdata),
    .btn_i  (btn_i),
    .sw_i   (sw_i),
    .led_o  (led_o)
  );

  // monitor: note read strobes at the edge, compare at the following negedge
  always @(posedge clk) rd_seen <= psel && !pwrite && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected read data actual=%h expected=<none>", prdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (prdata !== e.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, prdata, e.exp);
        end
      end
    end
  end

  task automatic do_reset();
    psel = 1'b0;
    rst  = 1'b1;
    repeat (3) @(negedge clk);
    rst  = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    psel = 1'b0; pwrite = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, e);
    end
  endtask

  initial begin
    do_reset();
    // R9 / R11: reset state; zero reload makes the event count run every clock
    rd(A_CNT,  32'd0, "R9 event count after reset");
    rd(A_PSC,  32'd0, "R11 prescaler stuck at zero");
    rd(A_CNT,  32'd2, "R11 event count per tick");
    rd(A_LED,  32'd0, "R9 LED word after reset");
    rd(A_MISC, 32'd0, "R9 control word after reset");
    rd(A_PRE,  32'd0, "R9 reload after reset");
    rd(A_SEC,  32'd0, "R9 second counter after reset");
    rd(A_CSEC, 32'd0, "R9 centisecond counter after reset");
    idle(1);
    check(32'(led_o), 32'd0, "R9 led_o after reset");

    // R2: LED masking
    wr(A_LED, 32'hFFFF_FFFF);
    rd(A_LED, 32'h0000_0003, "R2 LED mask readback");
    check(32'(led_o), 32'd3, "R2 led_o all on");
    wr(A_LED, 32'h0000_0006);
    check(32'(led_o), 32'd2, "R2 led_o pattern");

    // R5: control word
    wr(A_MISC, 32'hDEAD_BEEF);
    rd(A_MISC, 32'hDEAD_BEEF, "R5 control word readback");

    // R3 / R4: unbuilt and empty offsets
    wr(A_DBG, 32'h0000_ABCD);
    rd(A_DBG, 32'd0, "R3 unbuilt debug word");
    wr(A_EMPT, 32'h1234_5678);
    rd(A_EMPT, 32'd0, "R4 empty offset read");
    rd(A_HOLE, 32'd0, "R4 hole offset read");
    rd(A_MISC, 32'hDEAD_BEEF, "R4 control word untouched");
    rd(A_LED | 12'h003, 32'd2, "R4 low address bits ignored");

    // R6: synchronized inputs
    btn_i = 4'h5; sw_i = 4'hA;
    idle(3);
    rd(A_BTN, 32'h0000_0005, "R6 button levels");
    rd(A_SW,  32'h0000_000A, "R6 R3 built switch levels");

    // R10 / R12: prescaler reload 3
    wr(A_PRE, 32'd3);
    wr(A_PSC, 32'd1);
    wr(A_CNT, 32'd100);
    rd(A_CNT, 32'd100, "R12 event count load wins");
    rd(A_CNT, 32'd101, "R10 increment on reload");
    rd(A_PSC, 32'd2,   "R10 reload then decrement");
    rd(A_PSC, 32'd1,   "R10 decrement");
    rd(A_CNT, 32'd101, "R10 count held while nonzero");
    rd(A_CNT, 32'd102, "R10 second reload");
    rd(A_PRE, 32'd3,   "R12 reload readback");
    wr(A_PSC, 32'd7);
    rd(A_PSC, 32'd7,   "R12 prescaler load wins over tick");

    // R7: centisecond divider boundary
    wr(A_CSEC, 32'd500);
    idle(19);
    rd(A_CSEC, 32'd500, "R7 before first centisecond tick");
    rd(A_CSEC, 32'd501, "R7 after first centisecond tick");

    // R7 / R8: second counter wrap
    wr(A_SEC, 32'hFFFF_FFFF);
    idle(1999);
    rd(A_SEC, 32'hFFFF_FFFF, "R7 before first second tick");
    rd(A_SEC, 32'd0,         "R8 wrap to zero");

    // R9: mid-run reset
    idle(1);
    do_reset();
    rd(A_CNT,  32'd0, "R9 event count after second reset");
    rd(A_PRE,  32'd0, "R9 reload after second reset");
    rd(A_LED,  32'd0, "R9 LED word after second reset");
    rd(A_MISC, 32'd0, "R9 control word after second reset");
    rd(A_CSEC, 32'd0, "R9 centisecond after second reset");
    idle(2);
    check(32'(led_o), 32'd0, "R9 led_o after second reset");
    check(32'(sb_q.size()), 32'd0, "R1 all reads answered");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule